// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Term Allocator

This block is the logic core of a small programmable logic device. A set of logic inputs, together with a set of local feedback inputs from the block's own macrocell slots, is expanded into true and complemented literals. A programmable AND plane forms a pool of product terms from those literals. An allocation plane then steers each product term into any number of OR sums, with one sum per macrocell slot. A term can feed several sums, and a sum can collect any number of terms. The path from the inputs to the sums is purely combinational.

The whole map is loaded through a serial port. Configuration bits are clocked into a shift chain while `cfgEn` is high. A rising edge on `cfgLoad` copies the chain into the active map in one step. The map is cleared by reset, so every sum reads 0 until the first commit. The sizes are parameters. The defaults are kept small so the block elaborates quickly and can be swept exhaustively. The full-size device uses 36 inputs, 90 terms and 18 sums.

Top module: `pterm_array`

## Requirements
- R1: After reset and before the first commit, every bit of `sumOut` is 0 for any `dataIn` and `fbIn`.
- R2: Literal index 2k is source bit k and literal 2k+1 is its complement. Source bits 0..NUM_IN-1 are `dataIn` and bits NUM_IN.. are `fbIn`. Term t is the AND of every literal l whose fuse bit is set. That fuse bit sits at map bit t*NUM_LIT+l.
- R3: A product term with no fuse bit set evaluates to 0.
- R4: Sum s is the OR of every term t whose allocation bit, at map bit NUM_PT*NUM_LIT + s*NUM_PT + t, is set. One term may be allocated to several sums at once.
- R5: A sum with no term allocated is 0.
- R6: The feedback inputs `fbIn` act as selectable literals in the same way as `dataIn`.
- R7: Shifting bits with `cfgEn` has no effect on `sumOut` until a commit.
- R8: A commit happens only on the rising edge of `cfgLoad`. Holding `cfgLoad` high while shifting leaves the active map unchanged.
- R9: `sumOut` follows `dataIn` and `fbIn` within the same clock cycle, with no register in the path.
- R10: Serial bits are shifted in most-significant first. After NUM_PT*NUM_LIT + NUM_SUM*NUM_PT shifts, the first bit sent is map bit MSB and the last bit sent is map bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rstN | input | 1 | Active-low reset; clears the shift chain and the active map |
| cfgEn | input | 1 | Shifts `cfgBit` into the chain on each rising edge of `clk` while high |
| cfgBit | input | 1 | Serial configuration data |
| cfgLoad | input | 1 | Commits the chain into the active map on its rising edge |
| dataIn | input | NUM_IN | Logic inputs |
| fbIn | input | NUM_SUM | Local feedback inputs from the macrocell slots |
| sumOut | output | NUM_SUM | One OR sum per macrocell slot |

## Verification
A wrong fuse or allocation bit in the active map shows up on `sumOut` at once, but only for the input patterns that the damaged term decides. For that reason every configuration is checked over all combinations of `dataIn` and `fbIn`, and the expected sums are computed from the map. A fault in the shift order or in the commit strobe corrupts the whole map, or leaves it stale. That is visible on the first sweep after the commit edge. An improper commit while `cfgLoad` is held high is caught by the sweep that follows the extra shifting.

// File: rtl/pterm_array_pkg.sv
package pterm_array_pkg;
  typedef struct packed {
    logic shift;
    logic commit;
  } cfgStrobe_t;
endpackage

// File: rtl/pterm_cfg_ctrl.sv
module pterm_cfg_ctrl
  import pterm_array_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEn,
  input  logic       cfgLoad,
  output cfgStrobe_t strb
);
  logic loadQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loadQ <= 1'b0;
    else       loadQ <= cfgLoad;
  end

  always_comb begin
    strb.shift  = cfgEn;
    strb.commit = cfgLoad & ~loadQ;
  end

  // A commit is a single-cycle pulse
  assert_commit_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !strb.commit);

  // A held-high load strobe never commits again
  assert_no_recommit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad && $past(cfgLoad)) |-> !strb.commit);
endmodule

// File: rtl/pterm_sop_datapath.sv
module pterm_sop_datapath
  import pterm_array_pkg::*;
#(
  parameter int NUM_IN  = 6,
  parameter int NUM_PT  = 10,
  parameter int NUM_SUM = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strb,
  input  logic               cfgBit,
  input  logic [NUM_IN-1:0]  dataIn,
  input  logic [NUM_SUM-1:0] fbIn,
  output logic [NUM_SUM-1:0] sumOut
);
  localparam int NUM_SRC   = NUM_IN + NUM_SUM;
  localparam int NUM_LIT   = 2 * NUM_SRC;
  localparam int FUSE_BITS = NUM_PT * NUM_LIT;
  localparam int ALOC_BITS = NUM_SUM * NUM_PT;
  localparam int CFG_BITS  = FUSE_BITS + ALOC_BITS;

  logic [CFG_BITS-1:0] shiftChain;
  logic [CFG_BITS-1:0] activeMap;
  logic [NUM_SRC-1:0]  srcVec;
  logic [NUM_LIT-1:0]  litVec;
  logic [NUM_PT-1:0]   termVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftChain <= '0;
      activeMap  <= '0;
    end else begin
      if (strb.shift)  shiftChain <= {shiftChain[CFG_BITS-2:0], cfgBit};
      if (strb.commit) activeMap  <= shiftChain;
    end
  end

  assign srcVec = {fbIn, dataIn};

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_lit
    assign litVec[2*k]   = srcVec[k];
    assign litVec[2*k+1] = ~srcVec[k];
  end

  for (genvar t = 0; t < NUM_PT; t++) begin : g_term
    logic [NUM_LIT-1:0] fuseRow;
    assign fuseRow    = activeMap[t*NUM_LIT +: NUM_LIT];
    assign termVec[t] = (|fuseRow) & (&(~fuseRow | litVec));

    // Unprogrammed term stays low
    assert_empty_term_low_R3: assert property (@(posedge clk) disable iff (!rstN)
      (fuseRow == '0) |-> !termVec[t]);
  end

  for (genvar s = 0; s < NUM_SUM; s++) begin : g_sum
    logic [NUM_PT-1:0] alocRow;
    assign alocRow   = activeMap[FUSE_BITS + s*NUM_PT +: NUM_PT];
    assign sumOut[s] = |(alocRow & termVec);

    // Sum with nothing allocated stays low
    assert_empty_sum_low_R5: assert property (@(posedge clk) disable iff (!rstN)
      (alocRow == '0) |-> !sumOut[s]);
  end

  // Outputs only move when inputs change or a commit lands
  assert_sums_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.commit) && $stable(dataIn) && $stable(fbIn)) |-> $stable(sumOut));
endmodule

// File: rtl/pterm_array.sv
module pterm_array
  import pterm_array_pkg::*;
#(
  parameter int NUM_IN  = 6,
  parameter int NUM_PT  = 10,
  parameter int NUM_SUM = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEn,
  input  logic               cfgBit,
  input  logic               cfgLoad,
  input  logic [NUM_IN-1:0]  dataIn,
  input  logic [NUM_SUM-1:0] fbIn,
  output logic [NUM_SUM-1:0] sumOut
);
  cfgStrobe_t strb;

  pterm_cfg_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgEn   (cfgEn),
    .cfgLoad (cfgLoad),
    .strb    (strb)
  );

  pterm_sop_datapath #(
    .NUM_IN  (NUM_IN),
    .NUM_PT  (NUM_PT),
    .NUM_SUM (NUM_SUM)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cfgBit (cfgBit),
    .dataIn (dataIn),
    .fbIn   (fbIn),
    .sumOut (sumOut)
  );
endmodule

// File: tb/pterm_array_tb.sv
module pterm_array_tb;
  localparam int NI  = 6;
  localparam int NP  = 10;
  localparam int NS  = 4;
  localparam int NL  = 2 * (NI + NS);
  localparam int FB  = NP * NL;
  localparam int CB  = FB + NS * NP;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgEn = 1'b0;
  logic          cfgBit = 1'b0;
  logic          cfgLoad = 1'b0;
  logic [NI-1:0] dataIn = '0;
  logic [NS-1:0] fbIn = '0;
  logic [NS-1:0] sumOut;

  int checks = 0;
  int failures = 0;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  pterm_array #(.NUM_IN(NI), .NUM_PT(NP), .NUM_SUM(NS)) u_dut (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgBit(cfgBit), .cfgLoad(cfgLoad),
    .dataIn(dataIn), .fbIn(fbIn), .sumOut(sumOut)
  );

  function automatic logic [NS-1:0] model(input logic [CB-1:0] m,
                                          input logic [NI-1:0] d,
                                          input logic [NS-1:0] f);
    logic [NI+NS-1:0] src;
    logic [NL-1:0]    lit;
    logic [NP-1:0]    term;
    logic [NS-1:0]    r;
    src = {f, d};
    for (int k = 0; k < NI + NS; k++) begin
      lit[2*k]   = src[k];
      lit[2*k+1] = !src[k];
    end
    for (int t = 0; t < NP; t++) begin
      logic anyF, allOk;
      anyF = 1'b0;
      allOk = 1'b1;
      for (int l = 0; l < NL; l++)
        if (m[t*NL + l]) begin
          anyF = 1'b1;
          if (!lit[l]) allOk = 1'b0;
        end
      term[t] = anyF && allOk;
    end
    r = '0;
    for (int s = 0; s < NS; s++)
      for (int t = 0; t < NP; t++)
        if (m[FB + s*NP + t] && term[t]) r[s] = 1'b1;
    return r;
  endfunction

  function automatic int unsigned nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  task automatic check(input string req, input logic [NS-1:0] got, input logic [NS-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s dataIn=%b fbIn=%b got=%b exp=%b", req, dataIn, fbIn, got, exp);
    end
  endtask

  // Serial load, MSB first (R10)
  task automatic shiftMap(input logic [CB-1:0] m);
    for (int i = CB - 1; i >= 0; i--) begin
      @(negedge clk);
      cfgEn  = 1'b1;
      cfgBit = m[i];
    end
    @(negedge clk);
    cfgEn = 1'b0;
  endtask

  task automatic pulseLoad();
    @(negedge clk);
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  // Exhaustive sweep; each check is taken one ns after the inputs change,
  // before any clock edge, so it also exercises R9
  task automatic sweep(input string req, input logic [CB-1:0] m);
    for (int v = 0; v < (1 << (NI + NS)); v++) begin
      @(negedge clk);
      {fbIn, dataIn} = v[NI+NS-1:0];
      #1;
      check(req, sumOut, model(m, dataIn, fbIn));
    end
  endtask

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog expired got=hang exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [CB-1:0] mapA, mapB, mapC, mapD, mapE;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: nothing committed yet, all sums low
    sweep("R1", '0);

    // R2/R4/R10: dense random map
    mapA = '0;
    for (int i = 0; i < FB; i++) if (nextRand() % 9 == 0) mapA[i] = 1'b1;
    for (int i = FB; i < CB; i++) if (nextRand() % 3 == 0) mapA[i] = 1'b1;
    shiftMap(mapA);
    pulseLoad();
    sweep("R2_R10", mapA);

    // R3/R4/R5: empty term on sum0, shared term on sums 1 and 2, sum3 unallocated
    mapB = '0;
    mapB[FB + 0*NP + 0] = 1'b1;
    mapB[1*NL + 0] = 1'b1;
    mapB[1*NL + 5] = 1'b1;
    mapB[FB + 1*NP + 1] = 1'b1;
    mapB[FB + 2*NP + 1] = 1'b1;
    shiftMap(mapB);
    pulseLoad();
    sweep("R3_R4_R5", mapB);

    // R6: feedback literals
    mapC = '0;
    mapC[0*NL + 2*(NI+0)]     = 1'b1;
    mapC[0*NL + 2*1 + 1]      = 1'b1;
    mapC[1*NL + 2*(NI+3) + 1] = 1'b1;
    mapC[2*NL + 2*(NI+2)]     = 1'b1;
    mapC[2*NL + 2*(NI+1) + 1] = 1'b1;
    mapC[FB + 0*NP + 0] = 1'b1;
    mapC[FB + 1*NP + 0] = 1'b1;
    mapC[FB + 1*NP + 1] = 1'b1;
    mapC[FB + 3*NP + 2] = 1'b1;
    shiftMap(mapC);
    pulseLoad();
    sweep("R6", mapC);

    // R7: shift another map without committing
    mapD = ~mapC;
    for (int i = 0; i < FB; i++) if (nextRand() % 4 != 0) mapD[i] = 1'b0;
    shiftMap(mapD);
    sweep("R7", mapC);

    // R8: commit mapD, hold load high while shifting mapE
    @(negedge clk);
    cfgLoad = 1'b1;
    mapE = '0;
    for (int i = 0; i < CB; i++) if (nextRand() % 5 == 0) mapE[i] = 1'b1;
    shiftMap(mapE);
    sweep("R8_held", mapD);
    @(negedge clk);
    cfgLoad = 1'b0;
    pulseLoad();
    sweep("R8_edge", mapE);

    // R1: reset clears the committed map
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    sweep("R1_rst", '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule